// File: doc/BRIEF.md
# Random Word Transfer Engine

This block joins a free-running random bit generator to a simple host register bus. The host sees two read-only registers. The first is a status word with a "word ready" flag and a "generator running" flag. The second is a random output register that hands over one fresh 32-bit word per read. A read of the output register before a fresh word exists is not answered with stale data. The bus acknowledge is held low, which inserts wait states, until the generator has shifted in a complete new word.

A built-in transfer sequencer lets the host request a batch of words without polling. The host writes a word count. The sequencer then waits for each fresh word, moves it into a 16-entry output FIFO, and counts down. When the count reaches zero it raises a level interrupt, which stays high until the host clears it or loads a new nonzero count. The entropy source is a stand-in: a 32-bit maximal-length Galois LFSR.

Top module: `rwx_engine`

## Requirements
- R1: After reset, a status read returns 0x8000_0000. Bit 31 (generator running) is 1, bit 18 (word ready) is 0 and every other bit is 0. At the same time `irq` is 0 and `fifo_valid` is 0.
- R2: The LFSR shifts once per cycle only while no word is ready. Word ready rises exactly 32 cycles after reset or after a word is consumed. Starting from the reset seed 0xACE1_2468, the k-th word handed out (k from 0) is the LFSR state after 32·(k+1) steps of `s -> (s >> 1) XOR (s[0] ? 0x8020_0003 : 0)`.
- R3: A read of the output register (address 1) while word ready is 0 keeps `bus_ack` low until word ready rises. The read then completes with the new word, and word ready drops in the next cycle.
- R4: Writes to address 0 (status) and address 1 (output) are acknowledged at once and have no effect. In particular, they do not consume the ready word.
- R5: The address map is 0 = status (read), 1 = random output (read), 2 = transfer count (write), 3 = control (write, bit 0 = 1 clears the interrupt). Reads of addresses 2 and 3 return 0.
- R6: After a nonzero count N is written, exactly N words move into the FIFO, in generator order, and then transfers stop.
- R7: `irq` rises when the count reaches zero. It is a level that holds until a control write with bit 0 set, or a write of a new nonzero count.
- R8: Writing a count of 0 starts no transfer, does not consume the ready word, and raises no interrupt.
- R9: While the FIFO holds 16 words, the sequencer pauses without losing its remaining count. It resumes once entries are popped.
- R10: If a host read of the output register and a sequencer transfer both want the same ready word in one cycle, the host wins. The sequencer takes the following word.
- R11: The LFSR never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access completes in the cycle it is high |
| irq | output | 1 | Transfer-complete interrupt (level) |
| fifo_pop | input | 1 | Remove the head FIFO entry |
| fifo_data | output | 32 | Head FIFO entry |
| fifo_valid | output | 1 | FIFO is not empty |

## Verification
Two functions can collide on one ready word: a host read of the output register and a sequencer transfer. The bench provokes this in a specific order. It first consumes a word so that word ready is low. It then loads a count of one and starts a host read. Both requesters are now waiting when the next word appears. The check passes if the host receives word k and the FIFO later yields word k+1, each compared against the bench's own LFSR model.

// File: rtl/rwx_pkg.sv
package rwx_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int READY_BIT = 18;
  localparam int ON_BIT    = 31;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT  = 2'd0,
    SEL_RAND  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  // One Galois step, shifting right with the feedback mask
  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s,
                                                  input logic [WORD_W-1:0] poly);
    return (s >> 1) ^ (s[0] ? poly : '0);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic ready, input logic on);
    logic [WORD_W-1:0] v;
    v            = '0;
    v[READY_BIT] = ready;
    v[ON_BIT]    = on;
    return v;
  endfunction
endpackage

// File: rtl/rwx_src.sv
module rwx_src
  import rwx_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 32'hACE1_2468,
  parameter logic [WORD_W-1:0] POLY = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              ready
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] state;
  logic [CNT_W-1:0]  shifts;

  assign ready = (shifts == FULL_CNT);
  assign word  = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEED;
      shifts <= '0;
    end else if (take) begin
      shifts <= '0;
    end else if (!ready) begin
      state  <= lfsr_step(state, POLY);
      shifts <= shifts + 1'b1;
    end
  end

  AST_SRC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);  // R11
  AST_TAKE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ready);  // R3
  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ready);  // R3
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !take) |=> (ready && $stable(word)));  // R2
endmodule

// File: rtl/rwx_fifo.sv
module rwx_fifo
  import rwx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] dout,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FILL_MAX = (PTR_W+1)'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W:0]    fill;
  logic              do_push, do_pop;

  assign full    = (fill == FILL_MAX);
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R9
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_MAX);  // R9
endmodule

// File: rtl/rwx_seq.sv
module rwx_seq #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             ready,
  input  logic             host_take,
  input  logic             fifo_full,
  output logic             seq_take,
  output logic             busy,
  output logic             irq
);
  logic [CNT_W-1:0] remain;
  logic             last_word;
  logic             load_nz;

  assign busy      = (remain != '0);
  assign load_nz   = load && (load_val != '0);
  assign seq_take  = busy && ready && !host_take && !fifo_full && !load;
  assign last_word = seq_take && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (seq_take) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (load_nz)   irq <= 1'b0;
    else if (last_word) irq <= 1'b1;
    else if (clr)       irq <= 1'b0;
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr && !load) |=> irq);  // R7
  AST_ZERO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0 && !irq) |=> (!busy && !irq));  // R8
  AST_PAUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fifo_full && !load) |=> $stable(remain));  // R9
endmodule

// File: rtl/rwx_engine.sv
module rwx_engine
  import rwx_pkg::*;
#(
  parameter int                FIFO_DEPTH = 16,
  parameter int                CNT_W      = 32,
  parameter logic [WORD_W-1:0] SEED       = 32'hACE1_2468,
  parameter logic [WORD_W-1:0] POLY       = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              irq,
  input  logic              fifo_pop,
  output logic [WORD_W-1:0] fifo_data,
  output logic              fifo_valid
);
  reg_sel_e          sel;
  logic              rd_stat, rd_rand, wr_count, wr_ctrl;
  logic              src_ready, src_take, host_take, seq_take, seq_busy;
  logic              fifo_full, fifo_empty;
  logic [WORD_W-1:0] src_word;

  assign sel      = reg_sel_e'(bus_addr);
  assign rd_stat  = bus_req && !bus_we && (sel == SEL_STAT);
  assign rd_rand  = bus_req && !bus_we && (sel == SEL_RAND);
  assign wr_count = bus_req && bus_we && (sel == SEL_COUNT);
  assign wr_ctrl  = bus_req && bus_we && (sel == SEL_CTRL);

  assign host_take = rd_rand && src_ready;
  assign src_take  = host_take || seq_take;
  assign bus_ack   = bus_req && !(rd_rand && !src_ready);

  always_comb begin
    bus_rdata = '0;
    if (rd_stat)      bus_rdata = pack_status(src_ready, 1'b1);
    else if (rd_rand) bus_rdata = src_word;
  end

  rwx_src #(.SEED(SEED), .POLY(POLY)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (src_take),
    .word  (src_word),
    .ready (src_ready)
  );

  rwx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_count),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .clr       (wr_ctrl && bus_wdata[0]),
    .ready     (src_ready),
    .host_take (host_take),
    .fifo_full (fifo_full),
    .seq_take  (seq_take),
    .busy      (seq_busy),
    .irq       (irq)
  );

  rwx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (seq_take),
    .din   (src_word),
    .pop   (fifo_pop),
    .dout  (fifo_data),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign fifo_valid = !fifo_empty;

  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rand && src_ready) |-> !seq_take);  // R10
  AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rand && bus_ack) |=> !src_ready);  // R3
  AST_STATUS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[ON_BIT] && bus_ack));  // R1
  AST_WRITE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && src_ready && !seq_busy) |=> src_ready);  // R4
  AST_SEQ_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !seq_take);  // R6
endmodule

// File: tb/sim_rwx_engine.sv
module sim_rwx_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  localparam logic [31:0] POLY = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, irq, fifo_pop, fifo_valid;
  logic [31:0] fifo_data;

  int errors = 0, checks = 0;
  bit done = 0, drain_en = 0;
  logic [31:0] model_s = SEED;
  logic [31:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rwx_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq(irq), .fifo_pop(fifo_pop),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: 32 feedback steps per word
  function automatic logic [31:0] next_word();
    for (int i = 0; i < 32; i++) begin
      if (model_s[0]) model_s = {1'b0, model_s[31:1]} ^ POLY;
      else            model_s = {1'b0, model_s[31:1]};
    end
    return model_s;
  endfunction

  // Scoreboard monitor: pops the FIFO and compares with the queue
  initial fifo_pop = 1'b0;
  always @(negedge clk) begin
    fifo_pop = 1'b0;
    if (drain_en && fifo_valid) begin
      if (expq.size() == 0) check(1'b0, "R6 unexpected word", fifo_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(fifo_data == e, "R6 fifo order", fifo_data, e);
      end
      fifo_pop = 1'b1;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; #1;
    d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic host_read(output logic [31:0] d, output int waits);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 2'd1; waits = 0; #1;
    while (!bus_ack) begin
      @(negedge clk); #1; waits++;
    end
    d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic load_count(input int n);
    for (int i = 0; i < n; i++) expq.push_back(next_word());
    bus_write(2'd2, n);
  endtask

  task automatic wait_irq(input int lim);
    int k = 0;
    while (!irq && k < lim) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    #1;
    check(irq == 0, "R1 irq", {31'b0, irq}, 0);
    check(fifo_valid == 0, "R1 fifo_valid", {31'b0, fifo_valid}, 0);
    peek(2'd0, d);
    check(d == 32'h8000_0000, "R1 status", d, 32'h8000_0000);

    // R3 wait states, R2 word value
    e = next_word();
    host_read(d, w);
    check(w > 0, "R3 wait states", w, 1);
    check(d == e, "R2 first word", d, e);

    // R2 exact ready timing: 32 cycles after consume
    repeat (31) @(posedge clk);
    @(negedge clk); #1;
    bus_req = 1; bus_addr = 2'd0; #1;
    check(bus_rdata[18] == 0, "R2 ready after 31", bus_rdata, 32'h8000_0000);
    bus_req = 0;
    @(negedge clk); #1;
    bus_req = 1; bus_addr = 2'd0; #1;
    check(bus_rdata == 32'h8004_0000, "R2 ready after 32", bus_rdata, 32'h8004_0000);
    bus_req = 0;

    // R4 writes to read-only registers ignored
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_write(2'd0, 32'h0000_0000);
    peek(2'd0, d);
    check(d == 32'h8004_0000, "R4 status unchanged", d, 32'h8004_0000);
    e = next_word();
    host_read(d, w);
    check(d == e && w == 0, "R4 word not consumed", d, e);

    // R5 write-only addresses read 0
    peek(2'd2, d);
    check(d == 0, "R5 count reads 0", d, 0);
    peek(2'd3, d);
    check(d == 0, "R5 ctrl reads 0", d, 0);

    // R6 R7 batch of 5
    drain_en = 1;
    load_count(5);
    wait_irq(600);
    check(irq == 1, "R7 irq raised", {31'b0, irq}, 1);
    repeat (60) @(negedge clk);
    check(irq == 1, "R7 irq holds", {31'b0, irq}, 1);
    check(expq.size() == 0, "R6 all words", expq.size(), 0);
    check(fifo_valid == 0, "R6 stops at count", {31'b0, fifo_valid}, 0);
    bus_write(2'd3, 32'h1);
    #1;
    check(irq == 0, "R7 irq cleared", {31'b0, irq}, 0);

    // R8 zero count
    load_count(0);
    repeat (80) @(negedge clk);
    check(irq == 0 && fifo_valid == 0, "R8 no transfer", {30'b0, irq, fifo_valid}, 0);
    peek(2'd0, d);
    check(d[18] == 1, "R8 word kept", d, 32'h8004_0000);

    // R9 full FIFO pause
    drain_en = 0;
    load_count(20);
    repeat (20*33 + 50) @(negedge clk);
    check(irq == 0, "R9 paused", {31'b0, irq}, 0);
    check(fifo_valid == 1, "R9 fifo holds", {31'b0, fifo_valid}, 1);
    drain_en = 1;
    wait_irq(800);
    repeat (4) @(negedge clk);
    check(irq == 1, "R9 resumed to end", {31'b0, irq}, 1);
    check(expq.size() == 0, "R9 all 20 words", expq.size(), 0);

    // R7 nonzero load clears irq
    load_count(1);
    #1;
    check(irq == 0, "R7 load clears", {31'b0, irq}, 0);
    wait_irq(200);
    check(irq == 1, "R7 irq again", {31'b0, irq}, 1);
    bus_write(2'd3, 32'h1);

    // R10 collision: host beats sequencer
    repeat (40) @(negedge clk);
    e = next_word();
    host_read(d, w);
    check(d == e, "R10 setup read", d, e);
    e = next_word();
    expq.push_back(next_word());
    bus_write(2'd2, 32'd1);
    host_read(d, w);
    check(w > 0, "R10 both waited", w, 1);
    check(d == e, "R10 host gets word k", d, e);
    wait_irq(200);
    repeat (4) @(negedge clk);
    check(irq == 1 && expq.size() == 0, "R10 seq gets word k+1", expq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule